// File: doc/BRIEF.md
# Pipelined bus register bridge

This block sits between a pipelined single-master bus port (the upstream side) and the port of a slave (the downstream side). It lets a designer cut long combinational paths without changing the transfer protocol. Three parameter bits decide independently which paths pass through a register: the request path (cycle, strobe, direction, address, write data, byte enables), the stall path back to the master, and the response path (acknowledge and read data). When all three bits are clear, every signal is a plain wire.

A transfer takes place on a clock edge where strobe is high and stall is low. The master slows the flow by dropping strobe, and the slave slows it by raising stall. Every accepted request reaches the slave exactly once and in the order it was accepted. Every acknowledge returns to the master once, in order, for reads and for writes alike. A registered stall path costs one wait state after each accepted transfer. It lets a request reach the slave in the same cycle in which the master sees it accepted, so the slave may acknowledge as early as the next cycle. When the master ends its cycle early, the downstream cycle is kept open until the held requests have been issued and their acknowledges have returned.

Top module: `wbp_regslice`

## Requirements
- R1: With all three register bits clear, the downstream outputs equal the upstream inputs in the same cycle (strobe qualified by cycle), and stall, acknowledge and read data pass back in the same cycle.
- R2: In every configuration, each request accepted upstream is issued downstream exactly once, in acceptance order, with its direction, address, write data and byte enables unchanged.
- R3: With request registering on, a request reaches the slave no earlier than one cycle after upstream acceptance. With no downstream stall and a continuous strobe, one transfer is accepted per cycle.
- R4: With stall registering on, upstream stall is high in the cycle after every upstream acceptance. With no downstream stall and a continuous strobe, successive acceptances are exactly two cycles apart.
- R5: With request registering off and stall registering on, a request can reach the slave in its acceptance cycle, and an acknowledge one cycle after downstream acceptance is delivered correctly.
- R6: With response registering on, each upstream acknowledge and its read data appear exactly one cycle after the downstream acknowledge. With it off, they appear in the same cycle.
- R7: Each accepted transfer gets exactly one upstream acknowledge, in order. For reads, the read data is the data the slave returned with that acknowledge, and no acknowledge appears beyond the accepted count.
- R8: Downstream cycle is high whenever upstream cycle is high. With request or stall registering on, after upstream cycle drops, downstream cycle stays high exactly while held requests or unacknowledged downstream transfers remain. With both off, downstream cycle equals upstream cycle.
- R9: During reset, upstream acknowledge, upstream stall, downstream strobe and downstream cycle are low.
- R10: With request or stall registering on, a downstream request presented while stalled stays asserted, with the same direction, address, data and byte enables, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_cyc | input | 1 | Master bus cycle |
| up_stb | input | 1 | Master request strobe |
| up_we | input | 1 | Master write enable |
| up_adr | input | AW | Master byte address |
| up_wdat | input | DW | Master write data |
| up_sel | input | DW/8 | Master byte enables |
| up_stall | output | 1 | Stall toward the master |
| up_ack | output | 1 | Acknowledge toward the master |
| up_rdat | output | DW | Read data toward the master |
| dn_cyc | output | 1 | Bus cycle toward the slave |
| dn_stb | output | 1 | Request strobe toward the slave |
| dn_we | output | 1 | Write enable toward the slave |
| dn_adr | output | AW | Byte address toward the slave |
| dn_wdat | output | DW | Write data toward the slave |
| dn_sel | output | DW/8 | Byte enables toward the slave |
| dn_stall | input | 1 | Slave stall |
| dn_ack | input | 1 | Slave acknowledge |
| dn_rdat | input | DW | Slave read data |

## Verification
All eight combinations of the register bits run side by side. Each combination first gets a burst with no stalls and then a stretch with random strobe gaps and random slave stalls. The bench targets the overflow case where a request is accepted while the registered output is stalled: a design without a working spare slot would drop or duplicate a request, which shows up as an address or data mismatch at the slave. It also checks the acceptance spacing and the wait state after each acceptance with stall registering on, where a leaky stall register would let two requests through back to back. It checks acknowledges that come only one cycle after acceptance, where a response stage that slips or merges acknowledges would break the exact one-cycle timing or the read data. It checks an early drop of the master cycle: a bridge that closed the downstream cycle too soon would strand held requests or outstanding acknowledges.

// File: rtl/wbp_regslice.sv
`timescale 1ns/1ps
module wbp_regslice #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter bit REG_REQ   = 1'b0,
  parameter bit REG_STALL = 1'b1,
  parameter bit REG_RSP   = 1'b0,
  parameter int PEND_W    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            up_cyc,
  input  logic            up_stb,
  input  logic            up_we,
  input  logic [AW-1:0]   up_adr,
  input  logic [DW-1:0]   up_wdat,
  input  logic [DW/8-1:0] up_sel,
  output logic            up_stall,
  output logic            up_ack,
  output logic [DW-1:0]   up_rdat,
  output logic            dn_cyc,
  output logic            dn_stb,
  output logic            dn_we,
  output logic [AW-1:0]   dn_adr,
  output logic [DW-1:0]   dn_wdat,
  output logic [DW/8-1:0] dn_sel,
  input  logic            dn_stall,
  input  logic            dn_ack,
  input  logic [DW-1:0]   dn_rdat
);
  localparam int SW    = DW / 8;
  localparam int PW    = 1 + AW + DW + SW;
  localparam bit HOLDS = REG_REQ | REG_STALL;

  logic          a_stb, b_stb, c_stb, b_stall, a_held, b_held;
  logic [PW-1:0] a_pl, b_pl, c_pl;

  assign a_stb = up_cyc & up_stb;
  assign a_pl  = {up_we, up_adr, up_wdat, up_sel};

  if (REG_STALL) begin : g_stall
    logic          stall_q, full_q, acc, full_d;
    logic [PW-1:0] hold_q;
    assign acc      = a_stb & ~stall_q;
    assign b_stb    = full_q | acc;
    assign b_pl     = full_q ? hold_q : a_pl;
    assign full_d   = b_stb & b_stall;
    assign up_stall = stall_q;
    assign a_held   = full_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        stall_q <= 1'b0;
        full_q  <= 1'b0;
      end else begin
        stall_q <= acc | full_d;
        full_q  <= full_d;
      end
    end
    always_ff @(posedge clk) begin
      if (acc & b_stall) hold_q <= a_pl;
    end
  end else begin : g_stall_wire
    assign b_stb    = a_stb;
    assign b_pl     = a_pl;
    assign up_stall = b_stall;
    assign a_held   = 1'b0;
  end

  if (REG_REQ) begin : g_req
    logic          out_v, skid_v, acc, load;
    logic [PW-1:0] out_q, skid_q;
    assign acc     = b_stb & ~skid_v;
    assign load    = ~out_v | ~dn_stall;
    assign c_stb   = out_v;
    assign c_pl    = out_q;
    assign b_stall = skid_v;
    assign b_held  = out_v | skid_v;
    always_ff @(posedge clk) begin
      if (rst) begin
        out_v  <= 1'b0;
        skid_v <= 1'b0;
      end else if (load) begin
        out_v  <= skid_v | acc;
        skid_v <= 1'b0;
      end else if (acc) begin
        skid_v <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (load)     out_q  <= skid_v ? skid_q : b_pl;
      else if (acc) skid_q <= b_pl;
    end
  end else begin : g_req_wire
    assign c_stb   = b_stb;
    assign c_pl    = b_pl;
    assign b_stall = dn_stall;
    assign b_held  = 1'b0;
  end

  assign dn_stb = c_stb;
  assign {dn_we, dn_adr, dn_wdat, dn_sel} = c_pl;

  if (HOLDS) begin : g_cyc
    logic [PEND_W-1:0] pend_q;
    logic              dn_take;
    assign dn_take = dn_stb & ~dn_stall;
    always_ff @(posedge clk) begin
      if (rst)                  pend_q <= '0;
      else if (dn_take & ~dn_ack) pend_q <= pend_q + PEND_W'(1);
      else if (~dn_take & dn_ack) pend_q <= pend_q - PEND_W'(1);
    end
    assign dn_cyc = up_cyc | a_held | b_held | (pend_q != '0);
  end else begin : g_cyc_wire
    assign dn_cyc = up_cyc;
  end

  if (REG_RSP) begin : g_rsp
    logic          ack_q;
    logic [DW-1:0] rdat_q;
    always_ff @(posedge clk) begin
      if (rst) ack_q <= 1'b0;
      else     ack_q <= dn_ack;
    end
    always_ff @(posedge clk) begin
      if (dn_ack) rdat_q <= dn_rdat;
    end
    assign up_ack  = ack_q;
    assign up_rdat = rdat_q;
  end else begin : g_rsp_wire
    assign up_ack  = dn_ack;
    assign up_rdat = dn_rdat;
  end
endmodule

module wbp_regslice_chk #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter bit REG_REQ   = 1'b0,
  parameter bit REG_STALL = 1'b1,
  parameter bit REG_RSP   = 1'b0
) (
  input logic            clk,
  input logic            rst,
  input logic            up_cyc,
  input logic            up_stb,
  input logic            up_stall,
  input logic            up_ack,
  input logic [DW-1:0]   up_rdat,
  input logic            dn_cyc,
  input logic            dn_stb,
  input logic            dn_we,
  input logic [AW-1:0]   dn_adr,
  input logic [DW-1:0]   dn_wdat,
  input logic [DW/8-1:0] dn_sel,
  input logic            dn_stall,
  input logic            dn_ack,
  input logic [DW-1:0]   dn_rdat
);
  logic       up_take, dn_take;
  logic [7:0] up_n, dn_n, ua_n, da_n;
  assign up_take = up_cyc & up_stb & ~up_stall;
  assign dn_take = dn_cyc & dn_stb & ~dn_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_n <= 8'd0; dn_n <= 8'd0; ua_n <= 8'd0; da_n <= 8'd0;
    end else begin
      if (up_take) up_n <= up_n + 8'd1;
      if (dn_take) dn_n <= dn_n + 8'd1;
      if (up_ack)  ua_n <= ua_n + 8'd1;
      if (dn_ack)  da_n <= da_n + 8'd1;
    end
  end

  // R2: downstream never runs ahead of upstream, at most three requests held
  a_r2_no_excess: assert property (@(posedge clk) disable iff (rst)
    (8'(up_n - dn_n) <= 8'd3));
  // R7: upstream acknowledges trail downstream ones by at most the response stage
  a_r7_ack_balance: assert property (@(posedge clk) disable iff (rst)
    (8'(da_n - ua_n) <= (REG_RSP ? 8'd1 : 8'd0)));
  a_r8_cyc_cover: assert property (@(posedge clk) disable iff (rst)
    up_cyc |-> dn_cyc);

  if (REG_REQ | REG_STALL) begin : g_hold
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (dn_stb & dn_stall) |=> (dn_stb && $stable({dn_we, dn_adr, dn_wdat, dn_sel})));
  end

  if (REG_STALL) begin : g_ws
    a_r4_wait_state: assert property (@(posedge clk) disable iff (rst)
      up_take |=> up_stall);
  end

  if (REG_RSP) begin : g_rsp
    a_r6_rsp_delay: assert property (@(posedge clk) disable iff (rst)
      dn_ack |=> (up_ack && up_rdat == $past(dn_rdat)));
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !dn_ack |=> !up_ack);
  end else begin : g_rsp_w
    a_r6_same_cycle: assert property (@(posedge clk) disable iff (rst)
      (up_ack == dn_ack) && (!dn_ack || up_rdat == dn_rdat));
  end
endmodule

bind wbp_regslice wbp_regslice_chk #(
  .AW(AW), .DW(DW), .REG_REQ(REG_REQ), .REG_STALL(REG_STALL), .REG_RSP(REG_RSP)
) u_chk (.*);

// File: tb/sim_wbp_regslice.sv
`timescale 1ns/1ps
module wbp_lane #(
  parameter bit RQ   = 1'b0,
  parameter bit ST   = 1'b0,
  parameter bit RS   = 1'b0,
  parameter int LANE = 0
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   errs,
  output int   checks
);
  localparam int NA = 40;
  localparam int NT = 120;

  logic        up_cyc, up_stb, up_we, up_stall, up_ack;
  logic [31:0] up_adr, up_wdat, up_rdat;
  logic [3:0]  up_sel;
  logic        dn_cyc, dn_stb, dn_we, dn_stall, dn_ack;
  logic [31:0] dn_adr, dn_wdat, dn_rdat;
  logic [3:0]  dn_sel;

  wbp_regslice #(.AW(32), .DW(32), .REG_REQ(RQ), .REG_STALL(ST), .REG_RSP(RS)) u0 (
    .clk(clk), .rst(rst),
    .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we), .up_adr(up_adr),
    .up_wdat(up_wdat), .up_sel(up_sel), .up_stall(up_stall), .up_ack(up_ack),
    .up_rdat(up_rdat),
    .dn_cyc(dn_cyc), .dn_stb(dn_stb), .dn_we(dn_we), .dn_adr(dn_adr),
    .dn_wdat(dn_wdat), .dn_sel(dn_sel), .dn_stall(dn_stall), .dn_ack(dn_ack),
    .dn_rdat(dn_rdat)
  );

  function automatic logic [31:0] e_adr(int k);
    return 32'h0001_0000 * 32'(LANE) + 32'(k) * 32'd4;
  endfunction
  function automatic logic e_we(int k);
    return (k % 3) == 1;
  endfunction
  function automatic logic [31:0] e_dat(int k);
    return (32'(k + 1) * 32'h9E37_79B9) ^ 32'(LANE);
  endfunction
  function automatic logic [3:0] e_sel(int k);
    return (k % 4 == 0) ? 4'hF : 4'(1 << (k % 4));
  endfunction
  function automatic logic [31:0] rd(logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL lane %0d %s actual=%h expected=%h", LANE, r, act, exp);
    end
  endtask

  int          ua [NT];
  int          due[NT];
  int          sa [NT];
  logic [15:0] lf;

  initial begin
    int   cyc_n, up_i, dn_idx, qh, ack_i, tail, d;
    bit   taken, ws_pend, prev_hold, ut, dt, exp_cyc;
    logic [68:0] prev_pl;
    errs = 0; checks = 0; done = 0;
    up_cyc = 0; up_stb = 0; up_we = 0; up_adr = '0; up_wdat = '0; up_sel = '0;
    dn_stall = 0; dn_ack = 0; dn_rdat = '0;
    lf = 16'hACE1 ^ 16'(LANE * 97);
    cyc_n = 0; up_i = 0; dn_idx = 0; qh = 0; ack_i = 0; tail = 0;
    taken = 0; ws_pend = 0; prev_hold = 0; prev_pl = '0;
    repeat (2) @(negedge clk);
    // R9: idle outputs while in reset
    chk(!up_ack && !dn_stb && !dn_cyc && !up_stall, "R9 reset state",
        {28'd0, dn_cyc, dn_stb, up_ack, up_stall}, 32'd0);
    wait (!rst);
    while (tail < 6 && cyc_n < 5000) begin
      @(negedge clk);
      cyc_n++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      dn_stall = (dn_idx >= NA) && lf[1];
      if (qh < dn_idx && due[qh] <= cyc_n) begin
        dn_ack = 1; dn_rdat = rd(e_adr(qh));
      end else begin
        dn_ack = 0; dn_rdat = 32'hBAD0_0000 | 32'(cyc_n);
      end
      if (taken) begin up_stb = 0; taken = 0; end
      if (!up_stb && up_i < NT && (up_i < NA || lf[2] || lf[5])) begin
        up_stb = 1; up_we = e_we(up_i); up_adr = e_adr(up_i);
        up_wdat = e_dat(up_i); up_sel = e_sel(up_i);
      end
      up_cyc = (up_i < NT);
      #1;
      ut = up_cyc & up_stb & ~up_stall;
      dt = dn_cyc & dn_stb & ~dn_stall;
      if (ws_pend) chk(up_stall, "R4 wait state after acceptance", {31'd0, up_stall}, 32'd1);
      ws_pend = 0;
      if (prev_hold)
        chk(dn_stb && {dn_we, dn_adr, dn_wdat, dn_sel} == prev_pl, "R10 stalled request stable",
            dn_adr, prev_pl[67:36]);
      prev_hold = (RQ | ST) && dn_stb && dn_stall;
      prev_pl = {dn_we, dn_adr, dn_wdat, dn_sel};
      if (up_cyc) exp_cyc = 1;
      else if (RQ | ST) exp_cyc = (up_i > dn_idx) || (dn_idx > qh);
      else exp_cyc = 0;
      chk(dn_cyc == exp_cyc, "R8 downstream cycle", {31'd0, dn_cyc}, {31'd0, exp_cyc});
      if (!RQ && !ST && !RS)
        chk(dn_stb == (up_cyc & up_stb) && up_stall == dn_stall && up_ack == dn_ack &&
            (!up_stb || (dn_adr == up_adr && dn_wdat == up_wdat && dn_we == up_we && dn_sel == up_sel)) &&
            (!dn_ack || up_rdat == dn_rdat),
            "R1 wire-through", dn_adr, up_adr);
      if (ut) begin
        ua[up_i] = cyc_n;
        if (up_i > 0 && up_i < NA)
          chk(cyc_n - ua[up_i-1] == (ST ? 2 : 1), ST ? "R4 acceptance spacing" : "R3 acceptance spacing",
              32'(cyc_n - ua[up_i-1]), ST ? 32'd2 : 32'd1);
        if (ST) ws_pend = 1;
        up_i++;
        taken = 1;
      end
      if (dt) begin
        if (dn_idx < NT) begin
          chk(dn_adr == e_adr(dn_idx) && dn_we == e_we(dn_idx) && dn_wdat == e_dat(dn_idx) &&
              dn_sel == e_sel(dn_idx), "R2 order and content", dn_adr, e_adr(dn_idx));
          chk(dn_idx < up_i && cyc_n >= ua[dn_idx] + (RQ ? 1 : 0), "R3 R5 issue cycle",
              32'(cyc_n), 32'(ua[dn_idx]));
          d = cyc_n + ((dn_idx < NA) ? 1 : 1 + ((dn_idx + LANE) % 2));
          if (dn_idx > 0 && d <= due[dn_idx-1]) d = due[dn_idx-1] + 1;
          due[dn_idx] = d;
        end else chk(0, "R2 duplicate request", 32'(dn_idx), 32'(NT));
        dn_idx++;
      end
      if (dn_ack) begin sa[qh] = cyc_n; qh++; end
      if (up_ack) begin
        if (ack_i < NT && ack_i < qh + (RS ? 1 : 0)) begin
          chk(cyc_n == sa[ack_i] + (RS ? 1 : 0), "R6 acknowledge timing",
              32'(cyc_n), 32'(sa[ack_i] + (RS ? 1 : 0)));
          if (!e_we(ack_i))
            chk(up_rdat == rd(e_adr(ack_i)), "R7 R5 read data", up_rdat, rd(e_adr(ack_i)));
        end else chk(0, "R7 extra acknowledge", 32'(ack_i), 32'(qh));
        ack_i++;
      end
      if (ack_i >= NT) tail++;
    end
    chk(ack_i == NT, "R7 acknowledge count", 32'(ack_i), 32'(NT));
    chk(dn_idx == NT, "R2 request count", 32'(dn_idx), 32'(NT));
    chk(!dn_cyc, "R8 idle after drain", {31'd0, dn_cyc}, 32'd0);
    done = 1;
  end
endmodule

module sim_wbp_regslice;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] done;
  int         e [8];
  int         c [8];

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_lane
    wbp_lane #(.RQ((g % 2) == 1), .ST(((g / 2) % 2) == 1), .RS((g / 4) == 1), .LANE(g)) ln (
      .clk(clk), .rst(rst), .done(done[g]), .errs(e[g]), .checks(c[g])
    );
  end

  initial begin
    int te, tc, n;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    n = 0;
    while (done !== 8'hFF && n < 20000) begin
      @(posedge clk);
      n++;
    end
    #1;
    te = 0; tc = 0;
    for (int i = 0; i < 8; i++) begin te += e[i]; tc += c[i]; end
    if (done !== 8'hFF) begin
      te++; tc++;
      $display("FAIL watchdog expired, lanes done=%b expected=11111111", done);
    end
    $display("Result: errors=%0d of %0d checks", te, tc);
    $finish;
  end
endmodule